// File: doc/BRIEF.md
# DisplayPort AUX Request Controller

This block is the register-facing half of a DisplayPort AUX channel master. A host describes a single AUX request through a small set of 32-bit registers: a target address, a control word that selects the command and the payload length, and up to four transmit data words. Setting the go bit hands the request to a link-side transaction port as a one-cycle strobe with the command, address, byte count and packed payload. The link side later returns a reply type, a byte count, error flags and receive data.

The block captures the reply into a status register and the receive data words, raises a done interrupt, and watches hot-plug-detect and a sink event input for interrupts of their own. Illegal requests are refused without reaching the link side. A request that gets no reply within a programmable number of cycles is closed with a timeout flag. Line coding, pads and link training live elsewhere.

Register word offsets: 0 control, 1 address, 2 status, 3 interrupt status, 4 interrupt enable, 8 to 11 transmit words, 12 to 15 receive words. Control fields: go/busy bit 16, command bits 15:12, address-only bit 8, length-minus-one bits 3:0.

Top module: `aux_xact_ctrl`

## Requirements
- R1: After reset the control, status (apart from the live hot-plug bit), interrupt status and interrupt enable registers read zero, and `irq_out` is low.
- R2: A control write with bit 16 set, while idle and legal, pulses `lnk_req_valid` for exactly one cycle after the write edge. It presents the command from bits 15:12, the address register, and a byte count of length field plus one, or zero when address-only bit 8 is set. Control bit 16 reads as one until the reply or timeout.
- R3: Payload byte k appears on `lnk_tx_data[8k+7:8k]`: byte 0 is in the low byte of transmit word 0 (offset 8), and byte 4 is in the low byte of transmit word 1.
- R4: Legal commands are I2C write 0, I2C read 1, I2C status-update 2, their middle-of-transaction forms 4, 5 and 6, native write 8 and native read 9. Address-only is legal only with the six I2C codes. An illegal go causes no link strobe, sets status bit 12 and raises the done interrupt.
- R5: While a request is in flight, writes to the control, address and transmit registers are ignored, and a second go launches nothing.
- R6: On a reply the status register holds the reply type in bits 19:16 (native ACK 0, NACK 1, DEFER 2, I2C NACK 4, I2C DEFER 8) and the reply count in bits 4:0. Done interrupt bit 0 is set and busy clears.
- R7: An ACK (type 0) to a read command (1, 5 or 9) with a nonzero length loads the receive words. Bytes at an index at or above the smaller of reply count and request length read zero. Any other reply leaves the receive words unchanged.
- R8: With no reply within TIMEOUT_CYC cycles, status bit 8 is set, the count reads zero and done is raised. A reply arriving afterwards changes nothing.
- R9: Link error inputs set sticky status bits 9 (receive), 10 (sink status) and 11 (no stop). A status write clears each of bits 12:8 written as one, so 0xF00 clears the four link errors and leaves bit 12.
- R10: Status bit 28 follows `hpd_in` live. A rising edge sets interrupt bit 3, a falling edge sets bit 2, and a high `sink_irq_in` sets bit 1.
- R11: Interrupt status bits clear when written as one, and a new event in the same cycle wins. `irq_out` is high whenever any status bit is set whose enable bit at offset 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| lnk_req_valid | output | 1 | One-cycle request strobe to the link side |
| lnk_cmd | output | 4 | Command code of the request |
| lnk_addr | output | ADDR_W | AUX target address |
| lnk_addr_only | output | 1 | Request carries no payload |
| lnk_len | output | 5 | Payload byte count, 0 to 16 |
| lnk_tx_data | output | 128 | Packed payload, byte k at bits 8k+7:8k |
| lnk_rsp_valid | input | 1 | Reply strobe from the link side |
| lnk_rsp_type | input | 4 | One-hot reply type, zero for native ACK |
| lnk_rsp_count | input | 5 | Reply byte count |
| lnk_rsp_err | input | 3 | Reply errors: bit 0 receive, bit 1 sink status, bit 2 no stop |
| lnk_rsp_data | input | 128 | Reply payload, byte k at bits 8k+7:8k |
| hpd_in | input | 1 | Hot-plug-detect level, synchronous to clk |
| sink_irq_in | input | 1 | Sink interrupt event |
| irq_out | output | 1 | Interrupt line |

## Verification
The bench builds the block with a 20-bit address and TIMEOUT_CYC set to 40, so the no-reply timeout and the late reply after it both fall inside a short run. It also drives the full 16-byte length, where the length field reaches its top value and the count carries into bit 4. A behavioural model tracks the in-flight flag, the timeout counter and the interrupt state every clock. It predicts the link strobe and the interrupt line, including refused requests and go writes that land while busy.

// File: rtl/auxc_pkg.sv
package auxc_pkg;
    localparam int DATA_WORDS = 4;
    localparam int WORD_W     = 32;
    localparam int DATA_BYTES = DATA_WORDS * (WORD_W / 8);
    localparam int LEN_W      = $clog2(DATA_BYTES);
    localparam int CNT_W      = LEN_W + 1;
    localparam int WIDX_W     = $clog2(DATA_WORDS);
    localparam int OFS_W      = 4;

    localparam logic [OFS_W-1:0] OFS_CTRL  = 4'd0;
    localparam logic [OFS_W-1:0] OFS_ADDR  = 4'd1;
    localparam logic [OFS_W-1:0] OFS_STAT  = 4'd2;
    localparam logic [OFS_W-1:0] OFS_ISTAT = 4'd3;
    localparam logic [OFS_W-1:0] OFS_IEN   = 4'd4;

    localparam int CTL_GO       = 16;
    localparam int CTL_CMD_LO   = 12;
    localparam int CTL_AO       = 8;
    localparam int STAT_HPD     = 28;
    localparam int STAT_TYPE_LO = 16;
    localparam int STAT_ERR_LO  = 8;

    localparam int ERR_N      = 5;
    localparam int ERR_TMO    = 0;
    localparam int ERR_RX     = 1;
    localparam int ERR_SINK   = 2;
    localparam int ERR_NOSTOP = 3;
    localparam int ERR_BAD    = 4;

    localparam int IRQ_N      = 4;
    localparam int IRQ_DONE   = 0;
    localparam int IRQ_SINK   = 1;
    localparam int IRQ_UNPLUG = 2;
    localparam int IRQ_PLUG   = 3;

    localparam logic [3:0] RPL_ACK = 4'h0;

    typedef struct packed {
        logic [3:0]       cmd;
        logic             addr_only;
        logic [LEN_W-1:0] len_m1;
    } req_ctl_t;

    typedef enum logic {ST_IDLE, ST_WAIT} seq_st_e;

    function automatic req_ctl_t ctl_from_word(logic [WORD_W-1:0] w);
        req_ctl_t r;
        r.cmd       = w[CTL_CMD_LO +: 4];
        r.addr_only = w[CTL_AO];
        r.len_m1    = w[LEN_W-1:0];
        return r;
    endfunction

    // I2C-over-AUX codes: 0,1,2 and 4,5,6 (bit 2 marks middle-of-transaction)
    function automatic logic cmd_is_i2c(logic [3:0] c);
        return (c[3] == 1'b0) && (c[1:0] != 2'b11);
    endfunction

    function automatic logic cmd_legal(logic [3:0] c, logic ao);
        return cmd_is_i2c(c) || (!ao && (c[3:1] == 3'b100));
    endfunction

    function automatic logic cmd_reads(logic [3:0] c);
        return ((c[3] == 1'b0) && (c[1:0] == 2'b01)) || (c == 4'h9);
    endfunction

    function automatic logic [CNT_W-1:0] req_bytes(req_ctl_t r);
        return r.addr_only ? '0 : CNT_W'(r.len_m1) + CNT_W'(1);
    endfunction
endpackage

// File: rtl/aux_xact_seq.sv
module aux_xact_seq
    import auxc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic legal_i,
    input  logic rsp_valid_i,
    output logic busy_o,
    output logic req_o,
    output logic rsp_take_o,
    output logic tmo_o,
    output logic reject_o
);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

    seq_st_e          st_q;
    logic [TMR_W-1:0] tmr_q;

    assign busy_o     = (st_q == ST_WAIT);
    assign rsp_take_o = busy_o && rsp_valid_i;
    assign tmo_o      = busy_o && !rsp_valid_i && (tmr_q == TMR_W'(TIMEOUT_CYC - 1));
    assign reject_o   = !busy_o && start_i && !legal_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
            req_o <= 1'b0;
        end else begin
            req_o <= 1'b0;
            case (st_q)
                ST_IDLE: if (start_i && legal_i) begin
                    st_q  <= ST_WAIT;
                    tmr_q <= '0;
                    req_o <= 1'b1;
                end
                ST_WAIT: if (rsp_take_o || tmo_o) st_q <= ST_IDLE;
                         else tmr_q <= tmr_q + TMR_W'(1);
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    p_req_single_r2: assert property (@(posedge clk) disable iff (rst) req_o |=> !req_o);
    p_req_in_flight_r2: assert property (@(posedge clk) disable iff (rst) req_o |-> busy_o);
    p_go_ignored_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> !req_o);
    p_timeout_ends_r8: assert property (@(posedge clk) disable iff (rst) tmo_o |=> !busy_o);
endmodule

// File: rtl/aux_irq_unit.sv
module aux_irq_unit
    import auxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done_i,
    input  logic             sink_i,
    input  logic             hpd_i,
    input  logic             clr_we_i,
    input  logic             en_we_i,
    input  logic [IRQ_N-1:0] wdata_i,
    output logic [IRQ_N-1:0] stat_o,
    output logic [IRQ_N-1:0] en_o,
    output logic             irq_o
);
    logic             hpd_q;
    logic [IRQ_N-1:0] set_v, clr_v;

    always_comb begin
        set_v             = '0;
        set_v[IRQ_DONE]   = done_i;
        set_v[IRQ_SINK]   = sink_i;
        set_v[IRQ_UNPLUG] = !hpd_i && hpd_q;
        set_v[IRQ_PLUG]   = hpd_i && !hpd_q;
        clr_v             = clr_we_i ? wdata_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hpd_q  <= 1'b0;
            stat_o <= '0;
            en_o   <= '0;
        end else begin
            hpd_q  <= hpd_i;
            stat_o <= (stat_o & ~clr_v) | set_v;
            if (en_we_i) en_o <= wdata_i;
        end
    end

    assign irq_o = |(stat_o & en_o);

    p_done_latched_r11: assert property (@(posedge clk) disable iff (rst)
        done_i |=> stat_o[IRQ_DONE]);
    p_plug_edge_r10: assert property (@(posedge clk) disable iff (rst)
        (hpd_i && !hpd_q) |=> stat_o[IRQ_PLUG]);
    p_unplug_edge_r10: assert property (@(posedge clk) disable iff (rst)
        (!hpd_i && hpd_q) |=> stat_o[IRQ_UNPLUG]);
endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
    import auxc_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr_en,
    input  logic [OFS_W-1:0]        reg_addr,
    input  logic [WORD_W-1:0]       reg_wdata,
    output logic [WORD_W-1:0]       reg_rdata,
    output logic                    lnk_req_valid,
    output logic [3:0]              lnk_cmd,
    output logic [ADDR_W-1:0]       lnk_addr,
    output logic                    lnk_addr_only,
    output logic [CNT_W-1:0]        lnk_len,
    output logic [DATA_BYTES*8-1:0] lnk_tx_data,
    input  logic                    lnk_rsp_valid,
    input  logic [3:0]              lnk_rsp_type,
    input  logic [CNT_W-1:0]        lnk_rsp_count,
    input  logic [2:0]              lnk_rsp_err,
    input  logic [DATA_BYTES*8-1:0] lnk_rsp_data,
    input  logic                    hpd_in,
    input  logic                    sink_irq_in,
    output logic                    irq_out
);
    req_ctl_t                ctl_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [WORD_W-1:0]       tx_q [DATA_WORDS];
    logic [WORD_W-1:0]       rx_q [DATA_WORDS];
    logic [3:0]              rtype_q;
    logic [CNT_W-1:0]        rcount_q;
    logic [ERR_N-1:0]        err_q, err_set, err_clr;
    logic [IRQ_N-1:0]        istat, ien;
    logic [DATA_BYTES*8-1:0] rx_next;
    logic [CNT_W-1:0]        nbytes, keep;
    logic [WIDX_W-1:0]       widx;
    logic wr_ctrl, wr_addr, wr_tx, wr_stat, start, legal;
    logic busy, rsp_take, tmo, reject, capture;

    assign widx    = reg_addr[WIDX_W-1:0];
    assign wr_ctrl = reg_wr_en && (reg_addr == OFS_CTRL);
    assign wr_addr = reg_wr_en && (reg_addr == OFS_ADDR);
    assign wr_stat = reg_wr_en && (reg_addr == OFS_STAT);
    assign wr_tx   = reg_wr_en && (reg_addr[3:2] == 2'b10);
    assign start   = wr_ctrl && reg_wdata[CTL_GO];
    assign legal   = cmd_legal(reg_wdata[CTL_CMD_LO +: 4], reg_wdata[CTL_AO]);

    aux_xact_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk(clk), .rst(rst), .start_i(start), .legal_i(legal),
        .rsp_valid_i(lnk_rsp_valid), .busy_o(busy), .req_o(lnk_req_valid),
        .rsp_take_o(rsp_take), .tmo_o(tmo), .reject_o(reject)
    );

    aux_irq_unit u_irq (
        .clk(clk), .rst(rst), .done_i(rsp_take || tmo || reject), .sink_i(sink_irq_in),
        .hpd_i(hpd_in), .clr_we_i(reg_wr_en && (reg_addr == OFS_ISTAT)),
        .en_we_i(reg_wr_en && (reg_addr == OFS_IEN)), .wdata_i(reg_wdata[IRQ_N-1:0]),
        .stat_o(istat), .en_o(ien), .irq_o(irq_out)
    );

    assign nbytes        = req_bytes(ctl_q);
    assign keep          = (lnk_rsp_count < nbytes) ? lnk_rsp_count : nbytes;
    assign capture       = rsp_take && (lnk_rsp_type == RPL_ACK) && cmd_reads(ctl_q.cmd)
                           && (nbytes != '0);
    assign lnk_cmd       = ctl_q.cmd;
    assign lnk_addr      = addr_q;
    assign lnk_addr_only = ctl_q.addr_only;
    assign lnk_len       = nbytes;

    generate
        for (genvar w = 0; w < DATA_WORDS; w++) begin : g_tx
            assign lnk_tx_data[w*WORD_W +: WORD_W] = tx_q[w];
        end
        for (genvar b = 0; b < DATA_BYTES; b++) begin : g_rx
            assign rx_next[b*8 +: 8] = (CNT_W'(b) < keep) ? lnk_rsp_data[b*8 +: 8] : 8'h00;
        end
    endgenerate

    always_comb begin
        err_set             = '0;
        err_set[ERR_TMO]    = tmo;
        err_set[ERR_RX]     = rsp_take && lnk_rsp_err[0];
        err_set[ERR_SINK]   = rsp_take && lnk_rsp_err[1];
        err_set[ERR_NOSTOP] = rsp_take && lnk_rsp_err[2];
        err_set[ERR_BAD]    = reject;
        err_clr             = wr_stat ? reg_wdata[STAT_ERR_LO +: ERR_N] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            addr_q   <= '0;
            rtype_q  <= '0;
            rcount_q <= '0;
            err_q    <= '0;
            for (int w = 0; w < DATA_WORDS; w++) begin
                tx_q[w] <= '0;
                rx_q[w] <= '0;
            end
        end else begin
            if (wr_ctrl && !busy) ctl_q  <= ctl_from_word(reg_wdata);
            if (wr_addr && !busy) addr_q <= reg_wdata[ADDR_W-1:0];
            if (wr_tx && !busy)   tx_q[widx] <= reg_wdata;
            if (rsp_take) begin
                rtype_q  <= lnk_rsp_type;
                rcount_q <= lnk_rsp_count;
            end else if (tmo) begin
                rcount_q <= '0;
            end
            if (capture)
                for (int w = 0; w < DATA_WORDS; w++) rx_q[w] <= rx_next[w*WORD_W +: WORD_W];
            err_q <= (err_q & ~err_clr) | err_set;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[3]) begin
            reg_rdata = reg_addr[2] ? rx_q[widx] : tx_q[widx];
        end else begin
            case (reg_addr)
                OFS_CTRL: begin
                    reg_rdata[CTL_GO]         = busy;
                    reg_rdata[CTL_CMD_LO +: 4] = ctl_q.cmd;
                    reg_rdata[CTL_AO]         = ctl_q.addr_only;
                    reg_rdata[LEN_W-1:0]      = ctl_q.len_m1;
                end
                OFS_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
                OFS_STAT: begin
                    reg_rdata[STAT_HPD]              = hpd_in;
                    reg_rdata[STAT_TYPE_LO +: 4]     = rtype_q;
                    reg_rdata[STAT_ERR_LO +: ERR_N]  = err_q;
                    reg_rdata[CNT_W-1:0]             = rcount_q;
                end
                OFS_ISTAT: reg_rdata[IRQ_N-1:0] = istat;
                OFS_IEN:   reg_rdata[IRQ_N-1:0] = ien;
                default:   reg_rdata = '0;
            endcase
        end
    end

    p_reject_no_launch_r4: assert property (@(posedge clk) disable iff (rst)
        reject |=> (!lnk_req_valid && err_q[ERR_BAD]));
    p_timeout_flag_r8: assert property (@(posedge clk) disable iff (rst)
        tmo |=> err_q[ERR_TMO]);
    p_ctl_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctl_q));
    p_reply_type_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_take |=> (rtype_q == $past(lnk_rsp_type)));
endmodule

// File: tb/sim_aux_xact_ctrl.sv
module sim_aux_xact_ctrl;
    localparam int PERIOD = 10;
    localparam int TMO    = 40;
    localparam int AW     = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr_en = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         lnk_req_valid, lnk_addr_only;
    logic [3:0]   lnk_cmd;
    logic [AW-1:0] lnk_addr;
    logic [4:0]   lnk_len;
    logic [127:0] lnk_tx_data;
    logic         lnk_rsp_valid = 1'b0;
    logic [3:0]   lnk_rsp_type = '0;
    logic [4:0]   lnk_rsp_count = '0;
    logic [2:0]   lnk_rsp_err = '0;
    logic [127:0] lnk_rsp_data = '0;
    logic         hpd_in = 1'b0;
    logic         sink_irq_in = 1'b0;
    logic         irq_out;

    int nchk = 0;
    int nerr = 0;

    aux_xact_ctrl #(.ADDR_W(AW), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lnk_req_valid(lnk_req_valid),
        .lnk_cmd(lnk_cmd), .lnk_addr(lnk_addr), .lnk_addr_only(lnk_addr_only),
        .lnk_len(lnk_len), .lnk_tx_data(lnk_tx_data), .lnk_rsp_valid(lnk_rsp_valid),
        .lnk_rsp_type(lnk_rsp_type), .lnk_rsp_count(lnk_rsp_count),
        .lnk_rsp_err(lnk_rsp_err), .lnk_rsp_data(lnk_rsp_data), .hpd_in(hpd_in),
        .sink_irq_in(sink_irq_in), .irq_out(irq_out)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: in-flight flag, timeout count, interrupt state
    function automatic logic legal_req(input logic [3:0] c, input logic ao);
        if (c inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6}) return 1'b1;
        if (c inside {4'd8, 4'd9}) return !ao;
        return 1'b0;
    endfunction

    logic       m_busy = 1'b0, m_req = 1'b0, m_hpd = 1'b0;
    int         m_tmr = 0;
    logic [3:0] m_int = '0, m_en = '0;

    always @(posedge clk) begin
        logic done;
        done  = 1'b0;
        m_req = 1'b0;
        if (rst) begin
            m_busy = 1'b0; m_tmr = 0; m_int = '0; m_en = '0; m_hpd = 1'b0;
        end else begin
            if (m_busy) begin
                if (lnk_rsp_valid) begin m_busy = 1'b0; done = 1'b1; end
                else if (m_tmr == TMO - 1) begin m_busy = 1'b0; done = 1'b1; end
                else m_tmr++;
            end else if (reg_wr_en && reg_addr == 4'd0 && reg_wdata[16]) begin
                if (legal_req(reg_wdata[15:12], reg_wdata[8])) begin
                    m_busy = 1'b1; m_tmr = 0; m_req = 1'b1;
                end else done = 1'b1;
            end
            if (reg_wr_en && reg_addr == 4'd3) m_int = m_int & ~reg_wdata[3:0];
            if (done) m_int[0] = 1'b1;
            if (sink_irq_in) m_int[1] = 1'b1;
            if (!hpd_in && m_hpd) m_int[2] = 1'b1;
            if (hpd_in && !m_hpd) m_int[3] = 1'b1;
            m_hpd = hpd_in;
            if (reg_wr_en && reg_addr == 4'd4) m_en = reg_wdata[3:0];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R11 irq line", irq_out, |(m_int & m_en));
            chk("R2 link strobe", lnk_req_valid, m_req);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic reply(input logic [3:0] t, input logic [4:0] c, input logic [2:0] e,
                         input logic [127:0] d);
        @(negedge clk);
        lnk_rsp_valid = 1'b1; lnk_rsp_type = t; lnk_rsp_count = c;
        lnk_rsp_err = e; lnk_rsp_data = d;
        @(negedge clk);
        lnk_rsp_valid = 1'b0;
    endtask

    localparam logic [31:0] GO = 32'h0001_0000;

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        rdchk("R1 ctrl", 4'd0, 32'h0);
        rdchk("R1 stat", 4'd2, 32'h0);
        rdchk("R1 istat", 4'd3, 32'h0);
        rdchk("R1 ien", 4'd4, 32'h0);
        chk("R1 irq", irq_out, 1'b0);
        wr(4'd4, 32'hF);

        // R2 R3 native write of 5 bytes
        wr(4'd1, 32'h12345);
        wr(4'd8, 32'h44332211);
        wr(4'd9, 32'h00000055);
        wr(4'd0, GO | (32'h8 << 12) | 32'd4);
        #1;
        chk("R2 strobe", lnk_req_valid, 1'b1);
        chk("R2 cmd", lnk_cmd, 4'h8);
        chk("R2 addr", lnk_addr, 20'h12345);
        chk("R2 len", lnk_len, 5'd5);
        chk("R2 addr-only", lnk_addr_only, 1'b0);
        chk("R3 payload", lnk_tx_data[39:0], 40'h5544332211);
        rdchk("R2 busy", 4'd0, 32'h18004);
        reply(4'h0, 5'd0, 3'b000, '0);
        rdchk("R6 stat ack", 4'd2, 32'h0);
        rdchk("R6 done irq", 4'd3, 32'h1);
        rdchk("R2 busy clear", 4'd0, 32'h08004);
        wr(4'd3, 32'h1);
        rdchk("R11 w1c", 4'd3, 32'h0);

        // R7 native read, 6 bytes
        wr(4'd0, GO | (32'h9 << 12) | 32'd5);
        reply(4'h0, 5'd6, 3'b000, {128{1'b1}});
        rdchk("R7 rx0", 4'd12, 32'hFFFFFFFF);
        rdchk("R7 rx1", 4'd13, 32'h0000FFFF);
        rdchk("R7 rx2", 4'd14, 32'h0);
        rdchk("R6 count", 4'd2, 32'h6);
        // R7 clip to request length (2) when reply claims 5
        wr(4'd0, GO | (32'h9 << 12) | 32'd1);
        reply(4'h0, 5'd5, 3'b000, {128{1'b1}});
        rdchk("R7 clip rx0", 4'd12, 32'h0000FFFF);
        rdchk("R7 clip rx1", 4'd13, 32'h0);
        // R7 NACK leaves receive words alone
        wr(4'd0, GO | (32'h9 << 12) | 32'd3);
        reply(4'h1, 5'd4, 3'b000, {64{2'b10}});
        rdchk("R7 nack keeps", 4'd12, 32'h0000FFFF);
        rdchk("R6 nack stat", 4'd2, 32'h10004);

        // R2 R4 address-only I2C read with MOT
        wr(4'd0, GO | (32'h5 << 12) | (32'h1 << 8));
        #1;
        chk("R4 ao strobe", lnk_req_valid, 1'b1);
        chk("R4 ao len", lnk_len, 5'd0);
        chk("R4 ao flag", lnk_addr_only, 1'b1);
        chk("R4 ao cmd", lnk_cmd, 4'h5);
        reply(4'h4, 5'd0, 3'b000, '0);
        rdchk("R6 i2c nack", 4'd2, 32'h40000);

        // R4 native read with address-only is refused
        wr(4'd3, 32'hF);
        wr(4'd0, GO | (32'h9 << 12) | (32'h1 << 8));
        #1;
        chk("R4 refused strobe", lnk_req_valid, 1'b0);
        rdchk("R4 bad flag", 4'd2, 32'h41000);
        rdchk("R4 done irq", 4'd3, 32'h1);
        rdchk("R4 not busy", 4'd0, 32'h09100);
        wr(4'd2, 32'h1000);
        rdchk("R9 clear bad", 4'd2, 32'h40000);
        // R4 unknown command 3
        wr(4'd0, GO | (32'h3 << 12) | 32'd2);
        rdchk("R4 bad cmd", 4'd2, 32'h41000);
        wr(4'd2, 32'h1000);

        // R5 go while busy
        wr(4'd0, GO | (32'h8 << 12));
        wr(4'd0, GO | (32'h9 << 12) | 32'd7);
        #1;
        chk("R5 no relaunch", lnk_req_valid, 1'b0);
        rdchk("R5 ctrl kept", 4'd0, 32'h18000);
        wr(4'd1, 32'hABCDE);
        wr(4'd8, 32'hDEADBEEF);
        reply(4'h2, 5'd0, 3'b000, '0);
        rdchk("R6 defer", 4'd2, 32'h20000);
        rdchk("R5 addr kept", 4'd1, 32'h12345);
        rdchk("R5 tx kept", 4'd8, 32'h44332211);

        // R8 timeout, then a late reply
        wr(4'd3, 32'hF);
        wr(4'd0, GO | (32'h9 << 12));
        repeat (TMO + 5) @(negedge clk);
        rdchk("R8 timeout", 4'd2, 32'h20100);
        rdchk("R8 done", 4'd3, 32'h1);
        reply(4'h1, 5'd3, 3'b111, '0);
        rdchk("R8 late ignored", 4'd2, 32'h20100);

        // R9 link errors and the group clear
        wr(4'd0, GO | (32'h8 << 12));
        reply(4'h0, 5'd0, 3'b101, '0);
        rdchk("R9 errors", 4'd2, 32'h00B00);
        wr(4'd0, GO | (32'hF << 12));
        rdchk("R9 with bad", 4'd2, 32'h01B00);
        wr(4'd2, 32'hF00);
        rdchk("R9 F00 clear", 4'd2, 32'h01000);
        wr(4'd2, 32'h1000);
        rdchk("R9 all clear", 4'd2, 32'h0);
        wr(4'd0, GO | (32'h8 << 12));
        reply(4'h0, 5'd0, 3'b010, '0);
        rdchk("R9 sink err", 4'd2, 32'h00400);
        wr(4'd2, 32'hF00);

        // R10 R11 hot plug, sink event, enable gating
        wr(4'd3, 32'hF);
        @(negedge clk); hpd_in = 1'b1;
        @(negedge clk);
        rdchk("R10 plug", 4'd3, 32'h8);
        rdchk("R10 hpd live", 4'd2, 32'h10000000);
        hpd_in = 1'b0;
        @(negedge clk);
        rdchk("R10 unplug", 4'd3, 32'hC);
        sink_irq_in = 1'b1;
        @(negedge clk); sink_irq_in = 1'b0;
        rdchk("R10 sink", 4'd3, 32'hE);
        wr(4'd4, 32'h1);
        chk("R11 gated", irq_out, 1'b0);
        wr(4'd4, 32'h2);
        chk("R11 enabled", irq_out, 1'b1);
        wr(4'd3, 32'h6);
        rdchk("R11 partial w1c", 4'd3, 32'h8);
        wr(4'd3, 32'h8);

        // R3 full 16-byte write
        wr(4'd8, 32'h03020100);
        wr(4'd9, 32'h07060504);
        wr(4'd10, 32'h0B0A0908);
        wr(4'd11, 32'h0F0E0D0C);
        wr(4'd0, GO | (32'h8 << 12) | 32'd15);
        #1;
        chk("R2 len 16", lnk_len, 5'd16);
        chk("R3 full payload", lnk_tx_data, 128'h0F0E0D0C0B0A09080706050403020100);
        reply(4'h0, 5'd0, 3'b000, '0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule